// File: doc/BRIEF.md
# Leaky-Bucket Reference Clock Activity Monitor

This block watches a single reference clock that has already been brought into the system clock domain. It decides for each accounting period whether the reference showed an activity fault. A fault means that at some point in the period, the time since the last rising edge of the reference reached a programmable gap window. Each faulty period adds one to a leaky bucket. Runs of clean periods drain the bucket. The bucket drives an activity alarm with hysteresis. The accounting period is 128 ms of system time, and it is given in system-clock ticks so that a short value can be used in simulation.

Four configuration sets hold the thresholds, the bucket size, the leak rate and the gap window. A select input chooses the set in use. A small register port reads and writes every field of every set. The block reports the alarm and its inverse, a valid flag. It also gives a one-cycle event on each alarm change, which an external interrupt latch can capture. A mask input suppresses that event.

Top module: `refclk_activity_mon`

## Requirements
- R1: The accounting timer ends a period every CYCLE_TICKS clock edges after reset, on edges CYCLE_TICKS, 2*CYCLE_TICKS and so on. The bucket and the alarm change only on those edges.
- R2: A period is faulty when, on any tick inside it, the count of ticks since the last rising edge of `ref_in` is at least the selected window. That count saturates at 255.
- R3: At the end of a faulty period the bucket becomes the smaller of fill+1 and the selected size, and the clean-period count restarts.
- R4: When the alarm is low and the updated fill is at least the selected upper threshold, the alarm rises at that period end.
- R5: A clean period adds one to a clean-period count. When that count reaches the selected decay value (0 acts as 1), the bucket drops by one, never below zero, and the count restarts.
- R6: When the alarm is high and the updated fill is at most the selected lower threshold, the alarm falls at that period end.
- R7: `cfg_addr` is {set index, field}. Field codes are 0 upper, 1 lower, 2 size, 3 decay and 4 window. Codes 5 to 7 read as zero and writes to them change nothing. Reads are combinational, writes take effect on the clock edge, and `set_sel` picks the set in use.
- R8: `valid` is high exactly when `alarm` is low.
- R9: `change_evt` is high for the single cycle after each edge on which the alarm changes, unless `evt_mask` was high before that edge.
- R10: During and after reset, `alarm` is 0, `valid` is 1 and `change_evt` is 0. Every set holds the reset defaults: upper 8, lower 4, size 12, decay 1 and window 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock level, already synchronised to `clk` |
| set_sel | input | SEL_W (2) | Configuration set in use |
| evt_mask | input | 1 | Suppresses `change_evt` when high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | {set index, 3-bit field code} |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| alarm | output | 1 | Activity alarm |
| valid | output | 1 | Reference usable (no alarm) |
| change_evt | output | 1 | One-cycle pulse on an alarm change |

## Verification
A period-end decision, the new alarm and `change_evt` all take effect on edge j*CYCLE_TICKS after reset. The bench counts edges from reset release and samples those outputs on the falling edge that follows. It samples again one edge later to confirm that the event has dropped, and once more halfway through the next period to confirm that the alarm holds. Register reads are combinational, so they are sampled one time unit after the address is driven. A write is visible from the next falling edge. The reference pattern switches only at period boundaries, and it restarts toggling a few ticks ahead of a clean period. This makes every period unambiguously faulty or clean for the bench's arithmetic model.

// File: rtl/lbm_pkg.sv
// Package: shared widths, field codes and the configuration set record
// for the leaky-bucket activity monitor.
package lbm_pkg;

    localparam int VAL_W   = 8;
    localparam int FIELD_W = 3;

    typedef enum logic [FIELD_W-1:0] {
        FLD_UPPER  = 3'd0,
        FLD_LOWER  = 3'd1,
        FLD_SIZE   = 3'd2,
        FLD_DECAY  = 3'd3,
        FLD_WINDOW = 3'd4
    } lbm_field_e;

    typedef struct packed {
        logic [VAL_W-1:0] upper;
        logic [VAL_W-1:0] lower;
        logic [VAL_W-1:0] size;
        logic [VAL_W-1:0] decay;
        logic [VAL_W-1:0] window;
    } lbm_set_t;

endpackage

// File: rtl/lbm_cfg_regs.sv
// Configuration bank: NUM_SETS records of five 8-bit fields.
// Address is {set index, field code}; field codes above FLD_WINDOW are
// read as zero and ignored on write. Reads are combinational.
// Assumes a synchronous active-low reset loading RST_SET into every set.
module lbm_cfg_regs
    import lbm_pkg::*;
#(
    parameter int       NUM_SETS = 4,
    parameter int       SEL_W    = 2,
    parameter int       ADDR_W   = SEL_W + FIELD_W,
    parameter lbm_set_t RST_SET  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VAL_W-1:0]  wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic [VAL_W-1:0]  rdata,
    output lbm_set_t          cur
);

    localparam logic [SEL_W:0] SETS_L = (SEL_W+1)'(NUM_SETS);

    logic [SEL_W-1:0]   a_set;
    logic [FIELD_W-1:0] a_fld;
    lbm_set_t           bank [NUM_SETS];
    lbm_set_t           rd_rec;

    assign a_set = addr[ADDR_W-1:FIELD_W];
    assign a_fld = addr[FIELD_W-1:0];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        lbm_set_t rec;
        logic     hit;

        assign hit = we && ({1'b0, a_set} == (SEL_W+1)'(g));

        // Load one field of this set on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rec <= RST_SET;
            end else if (hit) begin
                case (a_fld)
                    FLD_UPPER:  rec.upper  <= wdata;
                    FLD_LOWER:  rec.lower  <= wdata;
                    FLD_SIZE:   rec.size   <= wdata;
                    FLD_DECAY:  rec.decay  <= wdata;
                    FLD_WINDOW: rec.window <= wdata;
                    default:    rec        <= rec;
                endcase
            end
        end

        assign bank[g] = rec;
    end

    // Pick the addressed record and field for the read port.
    always_comb begin
        rd_rec = ({1'b0, a_set} < SETS_L) ? bank[a_set] : '0;
        case (a_fld)
            FLD_UPPER:  rdata = rd_rec.upper;
            FLD_LOWER:  rdata = rd_rec.lower;
            FLD_SIZE:   rdata = rd_rec.size;
            FLD_DECAY:  rdata = rd_rec.decay;
            FLD_WINDOW: rdata = rd_rec.window;
            default:    rdata = '0;
        endcase
    end

    // Present the record chosen by the set select to the monitor.
    always_comb begin
        cur = ({1'b0, sel} < SETS_L) ? bank[sel] : '0;
    end

endmodule

// File: rtl/lbm_fault_det.sv
// Fault detector: times the accounting period and flags a period as
// faulty when the tick count since the last rising edge of ref_in
// reaches the gap window. Assumes ref_in is already synchronous to clk.
// cyc_end marks the last tick of a period; cyc_fault is valid with it.
module lbm_fault_det
    import lbm_pkg::*;
#(
    parameter int CYCLE_TICKS = 32_000_000,
    parameter int CNT_W       = $clog2(CYCLE_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [VAL_W-1:0] window,
    output logic             cyc_end,
    output logic             cyc_fault
);

    localparam logic [CNT_W-1:0] LAST    = CNT_W'(CYCLE_TICKS - 1);
    localparam logic [VAL_W-1:0] GAP_MAX = '1;

    logic             ref_q;
    logic             rise;
    logic             hit;
    logic             seen;
    logic [VAL_W-1:0] gap;
    logic [CNT_W-1:0] tick;

    assign rise      = ref_in & ~ref_q;
    assign hit       = (gap >= window);
    assign cyc_end   = (tick == LAST);
    assign cyc_fault = seen | hit;

    // Remember the previous reference level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_in;
    end

    // Count ticks since the last rising edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap <= '0;
        else if (rise)           gap <= '0;
        else if (gap != GAP_MAX) gap <= gap + 1'b1;
    end

    // Accounting period timer.
    always_ff @(posedge clk) begin
        if (!rst_n)       tick <= '0;
        else if (cyc_end) tick <= '0;
        else              tick <= tick + 1'b1;
    end

    // Sticky fault flag for the current period.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen <= 1'b0;
        else if (cyc_end) seen <= 1'b0;
        else              seen <= seen | hit;
    end

endmodule

// File: rtl/lbm_bucket.sv
// Leaky bucket with hysteresis alarm. At each period end the fill rises
// on a faulty period (saturating at size) or leaks by one after `decay`
// consecutive clean periods (0 treated as 1, floor zero). The alarm sets
// at fill >= upper and clears at fill <= lower. change_evt pulses for one
// cycle after an alarm change unless masked.
module lbm_bucket
    import lbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_end,
    input  logic             cyc_fault,
    input  logic [VAL_W-1:0] upper,
    input  logic [VAL_W-1:0] lower,
    input  logic [VAL_W-1:0] size,
    input  logic [VAL_W-1:0] decay,
    input  logic             evt_mask,
    output logic [VAL_W-1:0] fill,
    output logic             alarm,
    output logic             change_evt
);

    logic [VAL_W-1:0] clean;
    logic [VAL_W-1:0] fill_nx;
    logic [VAL_W-1:0] clean_nx;
    logic [VAL_W-1:0] dec_eff;
    logic             alarm_nx;

    assign dec_eff = (decay == '0) ? VAL_W'(1) : decay;

    // Next bucket, clean count and alarm state at a period end.
    always_comb begin
        fill_nx  = fill;
        clean_nx = clean;
        alarm_nx = alarm;
        if (cyc_end) begin
            if (cyc_fault) begin
                fill_nx  = (fill >= size) ? size : fill + 1'b1;
                clean_nx = '0;
            end else if (({1'b0, clean} + 1'b1) >= {1'b0, dec_eff}) begin
                fill_nx  = (fill == '0) ? '0 : fill - 1'b1;
                clean_nx = '0;
            end else begin
                clean_nx = clean + 1'b1;
            end
            if (!alarm && (fill_nx >= upper))     alarm_nx = 1'b1;
            else if (alarm && (fill_nx <= lower)) alarm_nx = 1'b0;
        end
    end

    // State registers and the change event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill       <= '0;
            clean      <= '0;
            alarm      <= 1'b0;
            change_evt <= 1'b0;
        end else begin
            fill       <= fill_nx;
            clean      <= clean_nx;
            alarm      <= alarm_nx;
            change_evt <= (alarm_nx != alarm) & ~evt_mask;
        end
    end

endmodule

// File: rtl/refclk_activity_mon.sv
// Top of the leaky-bucket reference clock activity monitor. It ties the
// configuration bank, the fault detector and the bucket together.
// Assumes ref_in is synchronous to clk and CYCLE_TICKS >= 2.
module refclk_activity_mon
    import lbm_pkg::*;
#(
    parameter int CYCLE_TICKS = 32_000_000,
    parameter int NUM_SETS    = 4,
    parameter int SEL_W       = $clog2(NUM_SETS),
    parameter int ADDR_W      = SEL_W + FIELD_W,
    parameter int RST_UPPER   = 8,
    parameter int RST_LOWER   = 4,
    parameter int RST_SIZE    = 12,
    parameter int RST_DECAY   = 1,
    parameter int RST_WINDOW  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [SEL_W-1:0]  set_sel,
    input  logic              evt_mask,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [VAL_W-1:0]  cfg_wdata,
    output logic [VAL_W-1:0]  cfg_rdata,
    output logic              alarm,
    output logic              valid,
    output logic              change_evt
);

    localparam lbm_set_t RST_SET = '{
        upper:  VAL_W'(RST_UPPER),
        lower:  VAL_W'(RST_LOWER),
        size:   VAL_W'(RST_SIZE),
        decay:  VAL_W'(RST_DECAY),
        window: VAL_W'(RST_WINDOW)
    };

    lbm_set_t         cur;
    logic             cyc_end;
    logic             cyc_fault;
    logic [VAL_W-1:0] fill;

    lbm_cfg_regs #(
        .NUM_SETS (NUM_SETS),
        .SEL_W    (SEL_W),
        .ADDR_W   (ADDR_W),
        .RST_SET  (RST_SET)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .sel   (set_sel),
        .rdata (cfg_rdata),
        .cur   (cur)
    );

    lbm_fault_det #(
        .CYCLE_TICKS (CYCLE_TICKS)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .window    (cur.window),
        .cyc_end   (cyc_end),
        .cyc_fault (cyc_fault)
    );

    lbm_bucket u_bkt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end    (cyc_end),
        .cyc_fault  (cyc_fault),
        .upper      (cur.upper),
        .lower      (cur.lower),
        .size       (cur.size),
        .decay      (cur.decay),
        .evt_mask   (evt_mask),
        .fill       (fill),
        .alarm      (alarm),
        .change_evt (change_evt)
    );

    assign valid = ~alarm;

endmodule

// File: rtl/lbm_checker.sv
// Checker for the activity monitor, attached to the top by bind.
// Relates the period strobe, the bucket fill, the thresholds and the alarm.
module lbm_checker
    import lbm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             alarm,
    input logic             change_evt,
    input logic             evt_mask,
    input logic             cyc_end,
    input logic             cyc_fault,
    input logic [VAL_W-1:0] fill,
    input logic [VAL_W-1:0] upper,
    input logic [VAL_W-1:0] lower,
    input logic [VAL_W-1:0] size
);

    p_hold_between_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> ($stable(alarm) && $stable(fill)));

    p_fill_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && cyc_fault) |=> (fill <= $past(size)));

    p_clean_never_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !cyc_fault) |=> (fill <= $past(fill)));

    p_rise_at_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (fill >= $past(upper)));

    p_fall_at_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> (fill <= $past(lower)));

    p_evt_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |-> (alarm != $past(alarm)));

    p_evt_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |-> !$past(evt_mask));

endmodule

bind refclk_activity_mon lbm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm      (alarm),
    .change_evt (change_evt),
    .evt_mask   (evt_mask),
    .cyc_end    (cyc_end),
    .cyc_fault  (cyc_fault),
    .fill       (fill),
    .upper      (cur.upper),
    .lower      (cur.lower),
    .size       (cur.size)
);

// File: tb/sim_refclk_activity_mon.sv
`timescale 1ns/1ps
module sim_refclk_activity_mon;

    localparam int CT   = 128;
    localparam int NCYC = 64;
    localparam int LOOK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] set_sel = 2'd0;
    logic       evt_mask = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = 5'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       alarm, valid, change_evt;

    always #2 clk = ~clk;

    refclk_activity_mon #(.CYCLE_TICKS(CT)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .set_sel(set_sel),
        .evt_mask(evt_mask), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .alarm(alarm),
        .valid(valid), .change_evt(change_evt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_edge = 0;
    bit done = 0;

    // Per-set values: upper, lower, size, decay, window
    int s_up  [4] = '{3, 2, 4, 2};
    int s_lo  [4] = '{1, 0, 2, 1};
    int s_sz  [4] = '{5, 3, 4, 6};
    int s_dc  [4] = '{1, 2, 1, 3};
    int s_win [4] = '{8, 8, 8, 3};

    bit dead_p [0:NCYC+1];
    int sel_p  [0:NCYC+1];
    bit mask_p [0:NCYC+1];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n_edge);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic seg(int a, int b, int s, bit m, bit d);
        for (int c = a; c <= b; c++) begin
            sel_p[c] = s; mask_p[c] = m; dead_p[c] = d;
        end
    endtask

    task automatic wr(int set, int fld, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'((set << 3) | fld); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(string req, int set, int fld, int exp);
        cfg_addr = 5'((set << 3) | fld);
        #1;
        chk(req, int'(cfg_rdata), exp);
    endtask

    always @(posedge clk) if (rst_n) n_edge <= n_edge + 1;

    // Reference pattern and per-period selection, driven off the clock edge.
    always @(negedge clk) begin
        int c0, c1;
        c0 = n_edge / CT + 1;
        c1 = (n_edge + LOOK) / CT + 1;
        if (c0 > NCYC + 1) c0 = NCYC + 1;
        if (c1 > NCYC + 1) c1 = NCYC + 1;
        if (!dead_p[c0] || !dead_p[c1]) ref_in <= n_edge[1];
        set_sel  <= 2'(sel_p[c0]);
        evt_mask <= mask_p[c0];
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int fill, clean, alm, prev, dec, s;
        bit faulty;
        string tag;
        fill = 0; clean = 0; alm = 0;
        for (int c = 0; c <= NCYC + 1; c++) begin
            sel_p[c] = 0; mask_p[c] = 0; dead_p[c] = 0;
        end
        seg(1, 6, 0, 0, 1);   seg(7, 14, 0, 0, 0);
        seg(15, 16, 1, 0, 1); seg(17, 20, 1, 0, 0);
        for (int c = 21; c <= 28; c++) begin
            sel_p[c] = 1; mask_p[c] = 0; dead_p[c] = (c % 2 == 1);
        end
        seg(29, 29, 2, 1, 0); seg(30, 31, 2, 1, 1); seg(32, 36, 2, 1, 0);
        seg(37, 44, 3, 0, 0); seg(45, 52, 2, 0, 0);
        for (int c = 53; c <= 60; c++) begin
            sel_p[c] = 0; mask_p[c] = 0;
            dead_p[c] = (c == 53 || c == 55 || c == 57 || c == 58 || c == 59);
        end
        seg(61, 64, 0, 0, 0);

        // R10: reset state and default register contents
        repeat (4) @(negedge clk);
        chk("R10 alarm", int'(alarm), 0);
        chk("R10 valid", int'(valid), 1);
        chk("R10 evt", int'(change_evt), 0);
        for (int st = 0; st < 4; st++) begin
            rd("R10 upper", st, 0, 8);  rd("R10 lower", st, 1, 4);
            rd("R10 size", st, 2, 12);  rd("R10 decay", st, 3, 1);
            rd("R10 window", st, 4, 255);
        end
        rst_n = 1'b1;

        // R7: program all sets, poke unused field codes, read back
        for (int st = 0; st < 4; st++) begin
            wr(st, 0, s_up[st]); wr(st, 1, s_lo[st]); wr(st, 2, s_sz[st]);
            wr(st, 3, s_dc[st]); wr(st, 4, s_win[st]);
        end
        wr(1, 5, 8'hAA); wr(1, 6, 8'h55); wr(1, 7, 8'hFF);
        @(negedge clk);
        for (int st = 0; st < 4; st++) begin
            rd("R7 upper", st, 0, s_up[st]);  rd("R7 lower", st, 1, s_lo[st]);
            rd("R7 size", st, 2, s_sz[st]);   rd("R7 decay", st, 3, s_dc[st]);
            rd("R7 window", st, 4, s_win[st]);
            rd("R7 unused5", st, 5, 0); rd("R7 unused6", st, 6, 0);
            rd("R7 unused7", st, 7, 0);
        end

        for (int j = 1; j <= NCYC; j++) begin
            s = sel_p[j];
            faulty = dead_p[j] || (s_win[s] <= 3);
            prev = alm;
            dec = (s_dc[s] == 0) ? 1 : s_dc[s];
            if (faulty) begin
                fill = (fill >= s_sz[s]) ? s_sz[s] : fill + 1;
                clean = 0;
            end else begin
                clean++;
                if (clean >= dec) begin
                    fill = (fill > 0) ? fill - 1 : 0;
                    clean = 0;
                end
            end
            if (alm == 0 && fill >= s_up[s]) alm = 1;
            else if (alm == 1 && fill <= s_lo[s]) alm = 0;

            if (alm == 1 && prev == 0)            tag = "R4 alarm set";
            else if (alm == 0 && prev == 1)       tag = "R6 alarm clear";
            else if (faulty && !dead_p[j])        tag = "R2 window fault";
            else if (faulty && fill == s_sz[s])   tag = "R3 saturate";
            else if (!faulty)                     tag = "R5 leak";
            else                                  tag = "R4 fill";

            // R1: mid-period the alarm still holds the previous decision
            while (n_edge != (j - 1) * CT + CT / 2) @(negedge clk);
            chk("R1 mid-period hold", int'(alarm), prev);

            while (n_edge != j * CT) @(negedge clk);
            chk(tag, int'(alarm), alm);
            chk("R8 valid", int'(valid), 1 - alm);
            chk("R9 evt", int'(change_evt), (alm != prev && !mask_p[j]) ? 1 : 0);

            @(negedge clk);
            chk("R9 evt one cycle", int'(change_evt), 0);
        end

        done = 1;
        report();
    end

endmodule